// File: doc/BRIEF.md
# Pipelined CORDIC Rotator / Vectoring Engine

This block is a fully unrolled CORDIC processor. It has one registered stage per iteration, and each stage has a fixed shift distance and a fixed arctangent constant, so the block needs no sequencer. On every clock edge it accepts a new triple of signed fixed-point words (x, y, angle). The transformed triple appears at the outputs a fixed number of cycles later. Several conversions can therefore be in flight at once.

The operating mode is a compile-time parameter, and the two modes use different sign rules.

- **Rotation mode** turns the input vector by the input angle. It serves polar-to-Cartesian conversion and sine/cosine generation. For sine/cosine, drive x with 1/K and y with zero.
- **Vectoring mode** drives y towards zero and accumulates the angle it rotated through. The results are the scaled magnitude and the phase.

**Number formats**

- Linear values are W-bit two's complement with +1.0 = 2^(W-2).
- Angles are W-bit two's complement with pi/2 = 2^(W-2), so pi maps to the wrap point of the word.
- Outputs carry the processing gain K (about 1.647 for 16 iterations). No gain compensation is applied.

**Resets**

- An asynchronous active-low reset empties every stage.
- A synchronous active-high clear does the same at a clock edge.

Top module: `cordic_pipe_top`

## Requirements
- R1: In rotation mode, each stage i applies x' = x - d*(y>>>i), y' = y + d*(x>>>i), a' = a - d*T(i), where T(i) = round(atan(2^-i)*2^(W-1)/pi). Here d = -1 if the stage's incoming angle is negative and d = +1 otherwise. The W-bit results wrap in two's complement.
- R2: In vectoring mode the same stage equations apply, with d = +1 if the stage's incoming y is negative and d = -1 otherwise. With a non-negative input x and an input vector magnitude of at most 1.0, the output x is non-negative.
- R3: A new input triple is taken at every rising clock edge with no handshake. The result of the triple sampled at an edge is on the outputs after exactly ITER rising edges, counting that edge, and not before.
- R4: While the active-low reset is low, all three outputs are zero, with no clock needed.
- R5: After a rising edge with the synchronous clear high, all outputs are zero. The triple presented at that edge and every triple in flight are discarded.
- R6: Sine/cosine use: with x0 = round(2^(W-2)/K), y0 = 0 and an angle within +-pi/2, the output x is within 24 LSB of cos(angle)*2^(W-2) and the output y is within 24 LSB of sin(angle)*2^(W-2) (W=16, ITER=16).
- R7: Vectoring use: for x0 > 0 and magnitude <= 1.0, the output x is within 24 LSB of K*sqrt(x0^2+y0^2). The output angle is within 24 LSB of atan2(y0,x0)*2^(W-1)/pi.
- R8: All shifts are arithmetic. Negative inputs rotate correctly: x0 = -1.0 at angle 0 gives an output x of about -K*2^(W-2).
- R9: The angle scale is pi/2 = 2^(W-2). Rotating (1.0, 0) by an input angle of +2^(W-2) gives an output of about (0, +K*2^(W-2)), and an angle of -2^(W-2) gives about (0, -K*2^(W-2)).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low, clears all stages |
| syncClr | input | 1 | Synchronous clear, active high, clears all stages |
| xIn | input | W | Input x (rotation: magnitude or 1/K; vectoring: abscissa) |
| yIn | input | W | Input y (rotation: usually 0; vectoring: ordinate) |
| aIn | input | W | Input angle (rotation: angle to apply; vectoring: 0) |
| xOut | output | W | Output x (rotation: scaled x or cos; vectoring: scaled magnitude) |
| yOut | output | W | Output y (rotation: scaled y or sin; vectoring: residual) |
| aOut | output | W | Output angle (vectoring: phase; rotation: residual) |

## Verification
The hardest behaviours to reach from the ports are the pipeline states when data is in flight in every stage.

- **Synchronous clear mid-stream:** a clear in the middle of a stream must drop the triples in all stages and still leave the pipeline consistent for the triples that follow. The stimulus streams a new random triple into both mode variants on every clock. It raises the clear partway through and later pulses the asynchronous reset between edges. A per-cycle reference model, which tracks every in-flight token, is then compared after each edge.
- **Exact latency:** this is checked with a single-cycle impulse against an all-zero background, so any off-by-one in stage count becomes visible.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  typedef enum logic {
    MODE_ROTATE = 1'b0,
    MODE_VECTOR = 1'b1
  } cordicMode_e;

  // Strobes from the control module to every datapath stage.
  typedef struct packed {
    logic clear;
    logic load;
  } pipeCtrl_t;

  localparam real PI_VAL = 3.14159265358979323846;

  // atan(2^-stage) on the angle scale where pi == 2^(width-1), rounded.
  function automatic longint atanScaled(input int stage, input int width);
    real r;
    r = $atan(2.0 ** (-stage)) * (2.0 ** (width - 1)) / PI_VAL;
    return longint'(r);
  endfunction

endpackage

// File: rtl/cordic_pipe_ctrl.sv
module cordic_pipe_ctrl (
  input  logic                  syncClr,
  output cordic_pkg::pipeCtrl_t ctl
);
  // No sequencing is needed: every stage loads each cycle unless cleared.
  always_comb begin
    ctl.clear = syncClr;
    ctl.load  = ~syncClr;
  end
endmodule

// File: rtl/cordic_stage.sv
module cordic_stage #(
  parameter int                      W     = 16,
  parameter int                      SHIFT = 0,
  parameter logic signed [W-1:0]     ATAN_K = '0,
  parameter cordic_pkg::cordicMode_e MODE  = cordic_pkg::MODE_ROTATE
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cordic_pkg::pipeCtrl_t ctl,
  input  logic signed [W-1:0]   xCur,
  input  logic signed [W-1:0]   yCur,
  input  logic signed [W-1:0]   aCur,
  output logic signed [W-1:0]   xNxt,
  output logic signed [W-1:0]   yNxt,
  output logic signed [W-1:0]   aNxt
);
  logic                turnPos;   // d == +1
  logic signed [W-1:0] xSh;
  logic signed [W-1:0] ySh;
  logic signed [W-1:0] xCalc;
  logic signed [W-1:0] yCalc;
  logic signed [W-1:0] aCalc;

  generate
    if (MODE == cordic_pkg::MODE_ROTATE) begin : g_rot
      always_comb turnPos = ~aCur[W-1];
    end else begin : g_vec
      always_comb turnPos = yCur[W-1];
    end
  endgenerate

  always_comb begin
    xSh = xCur >>> SHIFT;
    ySh = yCur >>> SHIFT;
    if (turnPos) begin
      xCalc = xCur - ySh;
      yCalc = yCur + xSh;
      aCalc = aCur - ATAN_K;
    end else begin
      xCalc = xCur + ySh;
      yCalc = yCur - xSh;
      aCalc = aCur + ATAN_K;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xNxt <= '0;
      yNxt <= '0;
      aNxt <= '0;
    end else if (ctl.clear) begin
      xNxt <= '0;
      yNxt <= '0;
      aNxt <= '0;
    end else if (ctl.load) begin
      xNxt <= xCalc;
      yNxt <= yCalc;
      aNxt <= aCalc;
    end
  end
endmodule

// File: rtl/cordic_pipe_top.sv
module cordic_pipe_top #(
  parameter int                      W    = 16,
  parameter int                      ITER = 16,
  parameter cordic_pkg::cordicMode_e MODE = cordic_pkg::MODE_ROTATE
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                syncClr,
  input  logic signed [W-1:0] xIn,
  input  logic signed [W-1:0] yIn,
  input  logic signed [W-1:0] aIn,
  output logic signed [W-1:0] xOut,
  output logic signed [W-1:0] yOut,
  output logic signed [W-1:0] aOut
);
  localparam int NODES = ITER + 1;

  cordic_pkg::pipeCtrl_t ctl;

  logic signed [W-1:0] xStg [NODES];
  logic signed [W-1:0] yStg [NODES];
  logic signed [W-1:0] aStg [NODES];

  cordic_pipe_ctrl u_ctrl (
    .syncClr (syncClr),
    .ctl     (ctl)
  );

  assign xStg[0] = xIn;
  assign yStg[0] = yIn;
  assign aStg[0] = aIn;

  generate
    for (genvar gi = 0; gi < ITER; gi++) begin : g_stage
      localparam logic signed [W-1:0] STAGE_ATAN = W'(cordic_pkg::atanScaled(gi, W));
      cordic_stage #(
        .W      (W),
        .SHIFT  (gi),
        .ATAN_K (STAGE_ATAN),
        .MODE   (MODE)
      ) u_stage (
        .clk  (clk),
        .rstN (rstN),
        .ctl  (ctl),
        .xCur (xStg[gi]),
        .yCur (yStg[gi]),
        .aCur (aStg[gi]),
        .xNxt (xStg[gi+1]),
        .yNxt (yStg[gi+1]),
        .aNxt (aStg[gi+1])
      );
    end
  endgenerate

  assign xOut = xStg[ITER];
  assign yOut = yStg[ITER];
  assign aOut = aStg[ITER];
endmodule

// File: rtl/cordic_pipe_chk.sv
module cordic_pipe_chk #(
  parameter int                      W    = 16,
  parameter int                      ITER = 16,
  parameter cordic_pkg::cordicMode_e MODE = cordic_pkg::MODE_ROTATE
) (
  input logic                clk,
  input logic                rstN,
  input logic                syncClr,
  input logic signed [W-1:0] xIn,
  input logic signed [W-1:0] yIn,
  input logic signed [W-1:0] xOut,
  input logic signed [W-1:0] yOut,
  input logic signed [W-1:0] aOut
);
  // One bit per in-flight token: were its x and y both zero on entry?
  // A cleared stage holds x=y=0, which stays zero downstream.
  logic [ITER-1:0] zeroHist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        zeroHist <= '1;
    else if (syncClr) zeroHist <= '1;
    else              zeroHist <= {zeroHist[ITER-2:0], (xIn == '0) && (yIn == '0)};
  end

  AST_ZERO_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    zeroHist[ITER-1] |-> (xOut == '0) && (yOut == '0)); // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    syncClr |=> (xOut == '0) && (yOut == '0) && (aOut == '0)); // R5

  always @(negedge clk) begin
    if (!rstN) begin
      AST_ASYNC_ZERO: assert ((xOut == '0) && (yOut == '0) && (aOut == '0)); // R4
    end
  end

  generate
    if (MODE == cordic_pkg::MODE_VECTOR) begin : g_vec
      logic [ITER-1:0] posHist;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        posHist <= '1;
        else if (syncClr) posHist <= '1;
        else              posHist <= {posHist[ITER-2:0], ~xIn[W-1]};
      end
      AST_VEC_X_NONNEG: assert property (@(posedge clk) disable iff (!rstN)
        posHist[ITER-1] |-> !xOut[W-1]); // R2
    end
  endgenerate
endmodule

bind cordic_pipe_top cordic_pipe_chk #(.W(W), .ITER(ITER), .MODE(MODE)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .syncClr (syncClr),
  .xIn     (xIn),
  .yIn     (yIn),
  .xOut    (xOut),
  .yOut    (yOut),
  .aOut    (aOut)
);

// File: tb/cordic_pipe_top_tb_top.sv
`timescale 1ns/1ps
module cordic_pipe_top_tb_top;
  localparam int  W    = 16;
  localparam int  ITER = 16;
  localparam int  ONE  = 1 << (W - 2);
  localparam real PI_R = 3.14159265358979323846;

  typedef struct {
    longint x;
    longint y;
    longint a;
  } tri_t;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic syncClr = 1'b0;
  logic signed [W-1:0] xr = '0, yr = '0, ar = '0;
  logic signed [W-1:0] xv = '0, yv = '0, av = '0;
  logic signed [W-1:0] xro, yro, aro, xvo, yvo, avo;

  int  checks = 0;
  int  failures = 0;
  bit  runCmp = 1'b0;
  bit  done = 1'b0;
  real gainK = 1.0;

  tri_t rotPipe [ITER];
  tri_t vecPipe [ITER];

  always #10 clk = ~clk;

  cordic_pipe_top #(.W(W), .ITER(ITER), .MODE(cordic_pkg::MODE_ROTATE)) dut_i (
    .clk(clk), .rstN(rstN), .syncClr(syncClr),
    .xIn(xr), .yIn(yr), .aIn(ar),
    .xOut(xro), .yOut(yro), .aOut(aro)
  );

  cordic_pipe_top #(.W(W), .ITER(ITER), .MODE(cordic_pkg::MODE_VECTOR)) vec_i (
    .clk(clk), .rstN(rstN), .syncClr(syncClr),
    .xIn(xv), .yIn(yv), .aIn(av),
    .xOut(xvo), .yOut(yvo), .aOut(avo)
  );

  function automatic longint wrapW(longint v);
    longint m;
    m = v & ((64'sd1 <<< W) - 1);
    if (m >= (64'sd1 <<< (W - 1))) m = m - (64'sd1 <<< W);
    return m;
  endfunction

  function automatic longint atanRef(int i);
    return longint'($atan(2.0 ** (-i)) * (2.0 ** (W - 1)) / PI_R);
  endfunction

  // One CORDIC iteration, from the requirement equations (R1 / R2).
  function automatic tri_t iterate(tri_t t, int i, bit vec);
    tri_t   r;
    longint d;
    if (vec) d = (t.y < 0) ? 1 : -1;
    else     d = (t.a < 0) ? -1 : 1;
    r.x = wrapW(t.x - d * (t.y >>> i));
    r.y = wrapW(t.y + d * (t.x >>> i));
    r.a = wrapW(t.a - d * atanRef(i));
    return r;
  endfunction

  // Reference model: each slot holds one token that has had s+1 iterations.
  always @(posedge clk or negedge rstN) begin
    if (!rstN || syncClr) begin
      for (int s = 0; s < ITER; s++) begin
        rotPipe[s] = '{0, 0, 0};
        vecPipe[s] = '{0, 0, 0};
      end
    end else begin
      for (int s = ITER - 1; s > 0; s--) begin
        rotPipe[s] = iterate(rotPipe[s-1], s, 1'b0);
        vecPipe[s] = iterate(vecPipe[s-1], s, 1'b1);
      end
      rotPipe[0] = iterate('{longint'(xr), longint'(yr), longint'(ar)}, 0, 1'b0);
      vecPipe[0] = iterate('{longint'(xv), longint'(yv), longint'(av)}, 0, 1'b1);
    end
  end

  task automatic chkEq(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic chkTol(string tag, longint act, real exp, int tol);
    longint e;
    longint d;
    e = longint'(exp);
    d = act - e;
    if (d < 0) d = -d;
    checks++;
    if (d > tol) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, e);
    end
  endtask

  // Per-cycle comparison against the model (R1 rotation, R2 vectoring).
  always @(negedge clk) begin
    if (runCmp) begin
      chkEq("R1 rot xOut", longint'(xro), rotPipe[ITER-1].x);
      chkEq("R1 rot yOut", longint'(yro), rotPipe[ITER-1].y);
      chkEq("R1 rot aOut", longint'(aro), rotPipe[ITER-1].a);
      chkEq("R2 vec xOut", longint'(xvo), vecPipe[ITER-1].x);
      chkEq("R2 vec yOut", longint'(yvo), vecPipe[ITER-1].y);
      chkEq("R2 vec aOut", longint'(avo), vecPipe[ITER-1].a);
    end
  end

  task automatic allZero(string tag);
    chkEq({tag, " rot x"}, longint'(xro), 0);
    chkEq({tag, " rot y"}, longint'(yro), 0);
    chkEq({tag, " rot a"}, longint'(aro), 0);
    chkEq({tag, " vec x"}, longint'(xvo), 0);
    chkEq({tag, " vec y"}, longint'(yvo), 0);
    chkEq({tag, " vec a"}, longint'(avo), 0);
  endtask

  task automatic rotCheck(string tag, int x0, int y0, real th);
    real c, s;
    xr = W'(x0); yr = W'(y0); ar = W'(int'(th * (2.0 ** (W - 1)) / PI_R));
    repeat (ITER + 1) @(negedge clk);
    c = $cos(th); s = $sin(th);
    chkTol({tag, " x"}, longint'(xro), gainK * (x0 * c - y0 * s), 24);
    chkTol({tag, " y"}, longint'(yro), gainK * (x0 * s + y0 * c), 24);
  endtask

  task automatic vecCheck(string tag, int x0, int y0);
    real mag, ph;
    xv = W'(x0); yv = W'(y0); av = '0;
    repeat (ITER + 1) @(negedge clk);
    mag = gainK * $sqrt(real'(x0) * x0 + real'(y0) * y0);
    ph  = $atan2(real'(y0), real'(x0)) * (2.0 ** (W - 1)) / PI_R;
    chkTol({tag, " mag"}, longint'(xvo), mag, 24);
    chkTol({tag, " phase"}, longint'(avo), ph, 24);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int invK;
    for (int i = 0; i < ITER; i++) gainK = gainK * $sqrt(1.0 + 2.0 ** (-2 * i));
    invK = int'(ONE / gainK);

    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    allZero("R4 initial reset");
    rstN = 1'b1;
    runCmp = 1'b1;

    // R3: single-cycle impulse on a zero background
    @(negedge clk);
    xr = W'(ONE / 2);
    for (int k = 1; k <= ITER; k++) begin
      @(negedge clk);
      if (k == 1) xr = '0;
      chkEq($sformatf("R3 impulse cycle %0d", k), longint'(xro != '0), longint'(k == ITER));
    end
    repeat (2) @(negedge clk);

    // Continuous random stream with a synchronous clear in the middle (R1 R2 R5 R8)
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      if (n == 151) begin
        syncClr = 1'b0;
        allZero("R5 clear");
      end
      xr = W'(int'($urandom_range(0, 2 * ONE)) - ONE);
      yr = W'(int'($urandom_range(0, ONE)) - ONE / 2);
      ar = W'(int'($urandom_range(0, 2 * ONE)) - ONE);
      xv = W'(int'($urandom_range(1, ONE / 2)));
      yv = W'(int'($urandom_range(0, ONE)) - ONE / 2);
      av = '0;
      if (n == 150) syncClr = 1'b1;
    end

    // R4: asynchronous reset between clock edges with data in flight
    @(negedge clk);
    #3 rstN = 1'b0;
    #1 allZero("R4 async mid-stream");
    @(negedge clk);
    rstN = 1'b1;
    xr = '0; yr = '0; ar = '0; xv = '0; yv = '0;

    // R6: sine / cosine
    rotCheck("R6 sincos 0", invK, 0, 0.0);
    rotCheck("R6 sincos pi/6", invK, 0, PI_R / 6.0);
    rotCheck("R6 sincos -pi/3", invK, 0, -PI_R / 3.0);
    rotCheck("R6 sincos 1.2", invK, 0, 1.2);
    // R9: angle scale pi/2 == 2^(W-2)
    rotCheck("R9 +quarter", ONE, 0, PI_R / 2.0);
    rotCheck("R9 -quarter", ONE, 0, -PI_R / 2.0);
    // R8: negative operands
    rotCheck("R8 neg x", -ONE, 0, 0.0);
    rotCheck("R8 neg xy", -ONE / 2, -ONE / 2, PI_R / 5.0);
    // R7: vectoring magnitude / phase
    vecCheck("R7 q1", ONE / 2, ONE / 2);
    vecCheck("R7 q4", ONE / 2, -ONE / 3);
    vecCheck("R7 axis", ONE, 0);
    vecCheck("R7 steep", ONE / 8, ONE / 2);

    runCmp = 1'b0;
    finishRun();
  end
endmodule